// File: doc/BRIEF.md
# Per-Slice Reconfigurable Broadcast Scan Decompressor

This block feeds a bank of internal scan chains from seven scan-in data pins. On every shift cycle a two-bit group code picks one of four modulo groupings: with modulus m, chain c takes its bit from data pin (c mod m). The moduli are 2, 3, 5 and 7. Because the code is taken afresh on each shift clock, every scan slice of a pattern can use its own grouping. External pattern-encoding software picks the code for each slice.

A pattern that no grouping can encode is loaded in serial mode. Chain 0 then takes data pin 0, and each later chain takes the scan-out of the chain before it. The bank becomes one long path with no broadcast.

The next slice passes through one register stage, so every chain input changes one clock after the inputs that produced it. When shift is disabled, every chain input is driven to 0. In serial mode this stage places one extra cell between each pair of linked chains.

Top module: `reconf_scan_decomp`

## Requirements
- R1: While reset (rst_n low) is asserted, every bit of chain_si is 0.
- R2: If shift_en is low at a clock edge, every bit of chain_si is 0 after that edge, whatever the other inputs are.
- R3: With shift_en high, serial_mode low and group_code 2'b00 (modulus 2) at an edge, chain_si[c] equals scan_pin[c mod 2] after that edge.
- R4: Under the same conditions with group_code 2'b01 (modulus 3), chain_si[c] equals scan_pin[c mod 3].
- R5: Under the same conditions with group_code 2'b10 (modulus 5), chain_si[c] equals scan_pin[c mod 5].
- R6: Under the same conditions with group_code 2'b11 (modulus 7), chain_si[c] equals scan_pin[c mod 7].
- R7: In a grouping with modulus m, the data pins m to 6 have no effect on chain_si.
- R8: group_code may change on every shift cycle. Each slice is mapped with the code present at its own clock edge.
- R9: With shift_en and serial_mode high at an edge, chain_si[0] equals scan_pin[0] after that edge. For c at least 1, chain_si[c] equals link_so[c-1].
- R10: In serial mode, group_code and data pins 1 to 6 have no effect on chain_si.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Shift enable; when low, all chain inputs are driven to 0 |
| serial_mode | input | 1 | Selects the concatenated serial path |
| group_code | input | 2 | Per-slice grouping code: 00 selects m=2, 01 selects m=3, 10 selects m=5, 11 selects m=7 |
| scan_pin | input | 7 | Scan-in data pins |
| link_so | input | NUM_CHAINS-1 | Scan-outs of chains 0 to NUM_CHAINS-2, used in serial mode |
| chain_si | output | NUM_CHAINS | Scan-in bit for each internal chain |

## Verification
The broadcast mapping is driven with single-hot and alternating pin words under every group code. A single hot pin shows exactly which chains a modulus connects to that pin, so a wrong modulus or a shifted index shows up at once. Vectors where only the pins above the active modulus are set tell a correct grouping apart from one that leaks unused pins. Serial vectors use distinct link patterns and toggle the ignored pins and code, and consecutive vectors change the code each cycle to show per-slice selection.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  // Number of selectable groupings and the widest modulus
  localparam int unsigned GROUP_CNT = 4;
  localparam int unsigned MAX_MOD   = 7;
  localparam int unsigned CODE_W    = $clog2(GROUP_CNT);

  typedef enum logic [CODE_W-1:0] {
    GRP_M2 = 2'b00,
    GRP_M3 = 2'b01,
    GRP_M5 = 2'b10,
    GRP_M7 = 2'b11
  } group_e;

  // Modulus for each grouping code
  function automatic int unsigned group_modulus(int unsigned code);
    case (code)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  // Data pin that drives a chain under a given grouping
  function automatic int unsigned pin_for_chain(int unsigned chain, int unsigned code);
    return chain % group_modulus(code);
  endfunction
endpackage

// File: rtl/rsd_broadcast.sv
module rsd_broadcast #(
  parameter int unsigned NUM_CHAINS = 12
) (
  input  logic [rsd_pkg::CODE_W-1:0]  code,
  input  logic [rsd_pkg::MAX_MOD-1:0] pins,
  output logic [NUM_CHAINS-1:0]       slice
);
  localparam int unsigned GC = rsd_pkg::GROUP_CNT;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    logic [GC-1:0] cand;
    for (genvar g = 0; g < GC; g++) begin : g_grp
      localparam int unsigned PIN = rsd_pkg::pin_for_chain(c, g);
      assign cand[g] = pins[PIN];
    end
    assign slice[c] = cand[code];
  end
endmodule

// File: rtl/rsd_serial.sv
module rsd_serial #(
  parameter int unsigned NUM_CHAINS = 12
) (
  input  logic                  head,
  input  logic [NUM_CHAINS-2:0] tails,
  output logic [NUM_CHAINS-1:0] slice
);
  // Chain 0 takes the pin; each later chain takes its predecessor's scan-out
  assign slice = {tails, head};
endmodule

// File: rtl/rsd_slice_reg.sv
module rsd_slice_reg #(
  parameter int unsigned NUM_CHAINS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  serial_mode,
  input  logic [NUM_CHAINS-1:0] bcast_slice,
  input  logic [NUM_CHAINS-1:0] serial_slice,
  output logic [NUM_CHAINS-1:0] slice_q
);
  logic [NUM_CHAINS-1:0] slice_next;

  always_comb begin
    if (!shift_en)        slice_next = '0;
    else if (serial_mode) slice_next = serial_slice;
    else                  slice_next = bcast_slice;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slice_q <= '0;
    else        slice_q <= slice_next;
  end
endmodule

// File: rtl/reconf_scan_decomp.sv
module reconf_scan_decomp #(
  parameter int unsigned NUM_CHAINS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift_en,
  input  logic                          serial_mode,
  input  logic [rsd_pkg::CODE_W-1:0]    group_code,
  input  logic [rsd_pkg::MAX_MOD-1:0]   scan_pin,
  input  logic [NUM_CHAINS-2:0]         link_so,
  output logic [NUM_CHAINS-1:0]         chain_si
);
  logic [NUM_CHAINS-1:0] bcast_slice;
  logic [NUM_CHAINS-1:0] serial_slice;
  logic                  bcast_shift;
  logic                  serial_shift;

  assign bcast_shift  = shift_en && !serial_mode;
  assign serial_shift = shift_en && serial_mode;

  rsd_broadcast #(.NUM_CHAINS(NUM_CHAINS)) u_bcast (
    .code  (group_code),
    .pins  (scan_pin),
    .slice (bcast_slice)
  );

  rsd_serial #(.NUM_CHAINS(NUM_CHAINS)) u_serial (
    .head  (scan_pin[0]),
    .tails (link_so),
    .slice (serial_slice)
  );

  rsd_slice_reg #(.NUM_CHAINS(NUM_CHAINS)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en     (shift_en),
    .serial_mode  (serial_mode),
    .bcast_slice  (bcast_slice),
    .serial_slice (serial_slice),
    .slice_q      (chain_si)
  );

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> chain_si == '0);

  // R9
  serial_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serial_shift |=> chain_si[0] == $past(scan_pin[0]));

  // R9
  serial_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serial_shift |=> chain_si[NUM_CHAINS-1:1] == $past(link_so));

  // R8
  slice_pin1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_shift |=> chain_si[1] == $past(scan_pin[1]));

  if (NUM_CHAINS > 2) begin : g_m2_chk
    // R3
    m2_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_shift && group_code == rsd_pkg::GRP_M2) |=> chain_si[2] == chain_si[0]);
  end
  if (NUM_CHAINS > 3) begin : g_m3_chk
    // R4
    m3_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_shift && group_code == rsd_pkg::GRP_M3) |=> chain_si[3] == chain_si[0]);
  end
  if (NUM_CHAINS > 5) begin : g_m5_chk
    // R5
    m5_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_shift && group_code == rsd_pkg::GRP_M5) |=> chain_si[5] == chain_si[0]);
  end
  if (NUM_CHAINS > 7) begin : g_m7_chk
    // R6
    m7_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_shift && group_code == rsd_pkg::GRP_M7) |=> chain_si[7] == chain_si[0]);
  end
endmodule

// File: tb/tb_reconf_scan_decomp.sv
`timescale 1ns/1ps
module tb_reconf_scan_decomp;
  localparam int NC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shift_en = 1'b0;
  logic          serial_mode = 1'b0;
  logic [1:0]    group_code = 2'b00;
  logic [6:0]    scan_pin = '0;
  logic [NC-2:0] link_so = '0;
  logic [NC-1:0] chain_si;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reconf_scan_decomp #(.NUM_CHAINS(NC)) dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .serial_mode(serial_mode),
    .group_code(group_code), .scan_pin(scan_pin), .link_so(link_so), .chain_si(chain_si)
  );

  // Vector layout: [20] serial, [19:18] code, [17:11] pins, [10:0] link_so
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 2'd0, 7'b0000001, 11'h000},  // R3 single hot pin 0
    {1'b0, 2'd0, 7'b0000010, 11'h000},  // R3 single hot pin 1
    {1'b0, 2'd1, 7'b0000100, 11'h000},  // R4 pin 2
    {1'b0, 2'd1, 7'b0000011, 11'h7FF},  // R4 with link noise
    {1'b0, 2'd2, 7'b0010000, 11'h000},  // R5 pin 4
    {1'b0, 2'd2, 7'b0001010, 11'h000},  // R5 alternating
    {1'b0, 2'd3, 7'b1000000, 11'h000},  // R6 pin 6
    {1'b0, 2'd3, 7'b0101011, 11'h000},  // R6 mixed
    {1'b0, 2'd0, 7'b1111100, 11'h000},  // R7 only unused pins for m=2
    {1'b0, 2'd2, 7'b1100000, 11'h000},  // R7 only unused pins for m=5
    {1'b0, 2'd1, 7'b1111000, 11'h000},  // R7 only unused pins for m=3
    {1'b1, 2'd0, 7'b0000001, 11'h555},  // R9 serial
    {1'b1, 2'd3, 7'b1111110, 11'h2A3},  // R10 serial, noisy pins and code
    {1'b1, 2'd2, 7'b0000000, 11'h7F0}   // R9 serial
  };

  // Expected slice, computed with a wrapping pin counter
  function automatic logic [NC-1:0] expect_slice(logic ser, logic [1:0] code,
                                                 logic [6:0] pins, logic [NC-2:0] so);
    logic [NC-1:0] r;
    int m;
    int k;
    r = '0;
    if (ser) begin
      r[0] = pins[0];
      for (int c = 1; c < NC; c++) r[c] = so[c-1];
    end else begin
      m = (code == 2'd0) ? 2 : (code == 2'd1) ? 3 : (code == 2'd2) ? 5 : 7;
      k = 0;
      for (int c = 0; c < NC; c++) begin
        r[c] = pins[k];
        k = k + 1;
        if (k == m) k = 0;
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: chain_si=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(logic ser, logic [1:0] code, logic [6:0] pins, logic [NC-2:0] so);
    serial_mode = ser;
    group_code  = code;
    scan_pin    = pins;
    link_so     = so;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] prev;
    // R1: reset state with active inputs
    apply(1'b0, 2'd0, 7'h7F, '1);
    shift_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", chain_si, '0);
    rst_n = 1'b1;

    // Table walk; code changes on consecutive cycles (R8)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][20], VEC[i][19:18], VEC[i][17:11], VEC[i][10:0]);
      @(negedge clk);
      check(VEC[i][20] ? "R9/R10 serial" : "R3-R7 broadcast", chain_si,
            expect_slice(VEC[i][20], VEC[i][19:18], VEC[i][17:11], VEC[i][10:0]));
    end

    // R8: code flips every cycle, each slice checked at its own edge
    for (int i = 0; i < 8; i++) begin
      apply(1'b0, 2'(i % 4), 7'b0110101 ^ 7'(i), '0);
      @(negedge clk);
      check("R8", chain_si, expect_slice(1'b0, 2'(i % 4), 7'b0110101 ^ 7'(i), '0));
    end

    // R7: explicit zero result with only unused pins high under m=2
    apply(1'b0, 2'd0, 7'b1111100, '0);
    @(negedge clk);
    check("R7", chain_si, '0);

    // R10: serial output independent of code and upper pins
    apply(1'b1, 2'd0, 7'b0000001, 11'h1C5);
    @(negedge clk);
    prev = chain_si;
    apply(1'b1, 2'd3, 7'b1111111, 11'h1C5);
    @(negedge clk);
    check("R10", chain_si, prev);

    // R2: shift disabled clears all chain inputs
    shift_en = 1'b0;
    apply(1'b0, 2'd3, 7'h7F, '1);
    @(negedge clk);
    check("R2", chain_si, '0);
    apply(1'b1, 2'd1, 7'h7F, '1);
    @(negedge clk);
    check("R2", chain_si, '0);
    shift_en = 1'b1;
    @(negedge clk);
    check("R9", chain_si, '1);

    // R1: reset in the middle of shifting
    rst_n = 1'b0;
    #1;
    check("R1", chain_si, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule